// File: doc/BRIEF.md
# UART Interrupt Priority Identification Unit

This block sits beside the receive and transmit datapaths of a 16550-style serial port. It keeps one pending flag for each interrupt cause: line error, received data, character timeout, transmit space and modem line change. It chooses the most urgent enabled cause by fixed priority and presents it as an identification byte for software to read. The block drives a single interrupt request line whenever any enabled cause is pending.

Each flag has its own set and clear rule. The datapath supplies the set events as pulses or levels. The register read and write strobes, decoded elsewhere, supply the clear events. The identification byte is registered one cycle behind the flag state and is frozen while a read strobe is held. A read therefore returns one coherent value. The transmit-space flag can be acknowledged by the read itself, but only when it is the cause that the read returned.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset `iir_data` is 0x01 and `irq` is 0. Bit 0 of `iir_data` is active low: it is 0 exactly when an enabled cause was pending in the previous cycle. `irq` is 1 when any enabled cause is pending.
- R2: The low nibble of `iir_data` is 0110 for a line error, 0100 for received data, 1100 for a character timeout, 0010 for transmit space, 0000 for a modem change and 0001 when no cause is pending. Bits 7:6 both equal `fifo_mode` and bits 5:4 are 0.
- R3: Priority from highest to lowest is line error, received data, character timeout, transmit space, modem change. Received data and timeout share a rank, and received data is reported when both are pending.
- R4: A `line_err` pulse sets the line flag. Only `rd_lsr` clears it. When both occur in the same cycle, the flag stays set.
- R5: When `fifo_mode`=0, a rising edge of `rx_full` sets the received-data flag and `rd_rbr` clears it.
- R6: When `fifo_mode`=1, a rising edge of `rx_trig` sets the received-data flag. The flag clears when `rx_trig` falls or when `rx_fifo_reset` is pulsed, and it stays clear while `rx_trig` remains high.
- R7: A `rx_tmo` pulse sets the timeout flag only when `fifo_mode`=1. `rd_rbr` or `rx_fifo_reset` clears it. A pulse while `fifo_mode`=0 has no effect.
- R8: A rising edge of `tx_space` sets the transmit flag, and `wr_thr` clears it.
- R9: The first cycle of a `rd_iir` strobe clears the transmit flag only when the held value reports transmit space (low nibble 0010). If another cause was reported, the transmit flag stays pending.
- R10: While `rd_iir` is high, `iir_data` holds the value it had when the strobe began, even when other causes change.
- R11: Any change on a `mdm_lines` bit sets the modem flag, and `rd_msr` clears it.
- R12: `src_en` bit 0 enables line error, bit 1 enables received data and timeout, bit 2 enables transmit space and bit 3 enables modem change. A disabled cause is neither encoded nor drives `irq`, but its flag keeps following its set and clear rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode | input | 1 | FIFO mode enable |
| src_en | input | 4 | Per-cause enables |
| line_err | input | 1 | Overrun, parity, framing or break event pulse |
| rx_full | input | 1 | Receive buffer full (non-FIFO mode) |
| rx_trig | input | 1 | Receive FIFO level at or above threshold |
| rx_tmo | input | 1 | Character timeout event pulse |
| tx_space | input | 1 | Holding register empty / transmit FIFO at most half full |
| mdm_lines | input | 4 | Modem input lines (CTS, DSR, RI, DCD) |
| rd_iir | input | 1 | Identification register read strobe |
| rd_lsr | input | 1 | Line status read strobe |
| rd_rbr | input | 1 | Receive buffer / FIFO read strobe |
| wr_thr | input | 1 | Transmit write strobe |
| rd_msr | input | 1 | Modem status read strobe |
| rx_fifo_reset | input | 1 | Receive FIFO reset strobe |
| iir_data | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
Some rules are checked by assertions on every cycle. These include the link between the pending bit and `irq`, the frozen value during a held read and the one-hot grant. They also cover set-over-clear on the line flag, the timeout flag staying clear outside FIFO mode, the clear on transmit write and the transmit flag surviving a read that reported another cause. The remaining behaviour needs the bench's scenarios: the full priority ordering, the exact nibble values and the masking of all cause/enable combinations. The scenarios also show that masked flags persist, how the timing of a read interacts with a new higher-priority event, and how the set/clear rules differ between FIFO and non-FIFO mode.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC   = 5;
  localparam int NEN    = 4;
  localparam int NMDM   = 4;
  localparam int EN_LINE = 0;
  localparam int EN_RX   = 1;
  localparam int EN_TX   = 2;
  localparam int EN_MDM  = 3;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_LINE = 3'd1,
    SRC_RXD  = 3'd2,
    SRC_TMO  = 3'd3,
    SRC_TX   = 3'd4,
    SRC_MDM  = 3'd5
  } src_e;

  typedef struct packed {
    logic mdm;
    logic tx;
    logic tmo;
    logic rxd;
    logic line;
  } pend_t;

  // Low nibble of the identification byte for a granted cause.
  function automatic logic [3:0] id_nibble(input src_e s);
    case (s)
      SRC_LINE: id_nibble = 4'b0110;
      SRC_RXD:  id_nibble = 4'b0100;
      SRC_TMO:  id_nibble = 4'b1100;
      SRC_TX:   id_nibble = 4'b0010;
      SRC_MDM:  id_nibble = 4'b0000;
      default:  id_nibble = 4'b0001;
    endcase
  endfunction

  function automatic logic [7:0] id_byte(input src_e s, input logic fifo);
    id_byte = {fifo, fifo, 2'b00, id_nibble(s)};
  endfunction
endpackage

// File: rtl/uart_irq_sources.sv
module uart_irq_sources
  import uart_irq_pkg::*;
#(
  parameter int MDM_W = NMDM
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_mode,
  input  logic             line_err,
  input  logic             rx_full,
  input  logic             rx_trig,
  input  logic             rx_tmo,
  input  logic             tx_space,
  input  logic [MDM_W-1:0] mdm_lines,
  input  logic             rd_lsr,
  input  logic             rd_rbr,
  input  logic             wr_thr,
  input  logic             rd_msr,
  input  logic             rx_fifo_reset,
  input  logic             tx_ack_rd,
  output pend_t            pend
);
  logic             full_d, trig_d, space_d;
  logic [MDM_W-1:0] mdm_d;
  logic             full_rise, trig_rise, space_rise;
  logic [MDM_W-1:0] mdm_chg_bit;
  logic             mdm_chg;
  logic             line_q, rxd_q, tmo_q, tx_q, mdm_q;

  assign full_rise  = rx_full  & ~full_d;
  assign trig_rise  = rx_trig  & ~trig_d;
  assign space_rise = tx_space & ~space_d;

  for (genvar g = 0; g < MDM_W; g++) begin : g_mdm
    assign mdm_chg_bit[g] = mdm_lines[g] ^ mdm_d[g];
  end
  assign mdm_chg = |mdm_chg_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_d  <= 1'b0;
      trig_d  <= 1'b0;
      space_d <= 1'b0;
      mdm_d   <= '0;
      line_q  <= 1'b0;
      rxd_q   <= 1'b0;
      tmo_q   <= 1'b0;
      tx_q    <= 1'b0;
      mdm_q   <= 1'b0;
    end else begin
      full_d  <= rx_full;
      trig_d  <= rx_trig;
      space_d <= tx_space;
      mdm_d   <= mdm_lines;
      line_q  <= line_err | (line_q & ~rd_lsr);
      if (fifo_mode)
        rxd_q <= rx_trig & ~rx_fifo_reset & (rxd_q | trig_rise);
      else
        rxd_q <= full_rise | (rxd_q & ~rd_rbr);
      tmo_q   <= fifo_mode & ~(rd_rbr | rx_fifo_reset) & (rx_tmo | tmo_q);
      tx_q    <= space_rise | (tx_q & ~(wr_thr | tx_ack_rd));
      mdm_q   <= mdm_chg | (mdm_q & ~rd_msr);
    end
  end

  assign pend = '{mdm: mdm_q, tx: tx_q, tmo: tmo_q, rxd: rxd_q, line: line_q};

  a_r4_line_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    line_q && !rd_lsr |=> line_q);
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    line_err |=> line_q);
  a_r4_line_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lsr && !line_err |=> !line_q);
  a_r7_tmo_fifo_only: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |=> !tmo_q);
  a_r8_tx_write_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_thr && !space_rise |=> !tx_q);
  a_r11_mdm_set: assert property (@(posedge clk) disable iff (!rst_n)
    mdm_chg |=> mdm_q);
endmodule

// File: rtl/uart_irq_prio_enc.sv
module uart_irq_prio_enc
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  pend_t           pend,
  input  logic [NEN-1:0]  en,
  output logic [NSRC-1:0] grant,
  output src_e            src,
  output logic            any
);
  logic [NSRC-1:0] req;

  // Index 0 is the most urgent cause.
  assign req[0] = pend.line & en[EN_LINE];
  assign req[1] = pend.rxd  & en[EN_RX];
  assign req[2] = pend.tmo  & en[EN_RX];
  assign req[3] = pend.tx   & en[EN_TX];
  assign req[4] = pend.mdm  & en[EN_MDM];

  always_comb begin
    grant = '0;
    for (int i = 0; i < NSRC; i++)
      if (req[i] && grant == '0) grant[i] = 1'b1;
  end

  always_comb begin
    src = SRC_NONE;
    for (int i = 0; i < NSRC; i++)
      if (grant[i]) src = src_e'(3'(i + 1));
  end

  assign any = |grant;

  a_r3_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  a_r12_line_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !en[EN_LINE] |-> !grant[0]);
  a_r3_line_first: assert property (@(posedge clk) disable iff (!rst_n)
    req[0] |-> grant[0]);
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_mode,
  input  logic [3:0] src_en,
  input  logic       line_err,
  input  logic       rx_full,
  input  logic       rx_trig,
  input  logic       rx_tmo,
  input  logic       tx_space,
  input  logic [3:0] mdm_lines,
  input  logic       rd_iir,
  input  logic       rd_lsr,
  input  logic       rd_rbr,
  input  logic       wr_thr,
  input  logic       rd_msr,
  input  logic       rx_fifo_reset,
  output logic [7:0] iir_data,
  output logic       irq
);
  pend_t           pend;
  logic [NSRC-1:0] grant;
  src_e            cur_src;
  logic            any_pend;
  logic            rd_d;
  logic            rd_start;
  logic            held_is_tx;
  logic            tx_ack_rd;
  logic [7:0]      iir_q;

  assign rd_start   = rd_iir & ~rd_d;
  assign held_is_tx = (iir_q[3:0] == id_nibble(SRC_TX));
  assign tx_ack_rd  = rd_start & held_is_tx;

  uart_irq_sources #(.MDM_W(NMDM)) u_src (
    .clk           (clk),
    .rst_n         (rst_n),
    .fifo_mode     (fifo_mode),
    .line_err      (line_err),
    .rx_full       (rx_full),
    .rx_trig       (rx_trig),
    .rx_tmo        (rx_tmo),
    .tx_space      (tx_space),
    .mdm_lines     (mdm_lines),
    .rd_lsr        (rd_lsr),
    .rd_rbr        (rd_rbr),
    .wr_thr        (wr_thr),
    .rd_msr        (rd_msr),
    .rx_fifo_reset (rx_fifo_reset),
    .tx_ack_rd     (tx_ack_rd),
    .pend          (pend)
  );

  uart_irq_prio_enc u_enc (
    .clk   (clk),
    .rst_n (rst_n),
    .pend  (pend),
    .en    (src_en),
    .grant (grant),
    .src   (cur_src),
    .any   (any_pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_d  <= 1'b0;
      iir_q <= 8'h01;
    end else begin
      rd_d <= rd_iir;
      if (!rd_iir) iir_q <= id_byte(cur_src, fifo_mode);
    end
  end

  assign iir_data = iir_q;
  assign irq      = any_pend;

  a_r1_pend_bit: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_iir |=> (iir_data[0] == !$past(irq)));
  a_r10_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_iir |=> $stable(iir_data));
  a_r9_tx_kept: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start && !held_is_tx && pend.tx && !wr_thr |=> pend.tx);
  a_r9_tx_acked: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ack_rd && !(tx_space && !$past(tx_space)) |=> !pend.tx);
endmodule

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_mode = 1'b1;
  logic [3:0] src_en = 4'hF;
  logic       line_err = 0, rx_full = 0, rx_trig = 0, rx_tmo = 0, tx_space = 0;
  logic [3:0] mdm_lines = 4'h0;
  logic       rd_iir = 0, rd_lsr = 0, rd_rbr = 0, wr_thr = 0, rd_msr = 0, rx_fifo_reset = 0;
  logic [7:0] iir_data;
  logic       irq;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  uart_irq_ident u0 (.*);

  function automatic logic [7:0] model(input logic [4:0] p, input logic [3:0] en, input logic f);
    logic [3:0] nib;
    if (p[0] && en[0])      nib = 4'h6;
    else if (p[1] && en[1]) nib = 4'h4;
    else if (p[2] && en[1]) nib = 4'hC;
    else if (p[3] && en[2]) nib = 4'h2;
    else if (p[4] && en[3]) nib = 4'h0;
    else                    nib = 4'h1;
    return {f, f, 2'b00, nib};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(2);
    chk("R1 reset iir", iir_data, 8'h01);
    chk("R1 reset irq", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    tick(2);
    chk("R2 idle fifo bits", iir_data, 8'hC1);

    // Sweep: every cause subset under every enable mask (R2 R3 R12).
    for (int p = 0; p < 32; p++) begin
      for (int e = 0; e < 16; e++) begin
        src_en   = 4'(e);
        line_err = p[0];
        rx_trig  = p[1];
        rx_tmo   = p[2];
        tx_space = p[3];
        if (p[4]) mdm_lines = mdm_lines ^ 4'b0001;
        tick(1);
        line_err = 0; rx_tmo = 0;
        tick(1);
        chk("R3 sweep encode", iir_data, model(5'(p), 4'(e), 1'b1));
        chk("R1 sweep irq", {7'd0, irq}, {7'd0, model(5'(p), 4'(e), 1'b1)[0] == 1'b0});
        src_en = 4'hF;
        tick(2);
        chk("R12 masked flags kept", iir_data, model(5'(p), 4'hF, 1'b1));
        rd_lsr = 1; rx_trig = 0; rd_rbr = 1; wr_thr = 1; rd_msr = 1; tx_space = 0;
        tick(1);
        rd_lsr = 0; rd_rbr = 0; wr_thr = 0; rd_msr = 0;
        tick(2);
        chk("R2 sweep cleared", iir_data, 8'hC1);
      end
    end

    // R9: read acknowledges transmit when it is the reported cause.
    tx_space = 1; tick(2);
    chk("R8 tx set", iir_data, 8'hC2);
    rd_iir = 1; tick(1); rd_iir = 0; tick(1);
    chk("R9 tx acked by read", iir_data, 8'hC1);
    tx_space = 0; tick(1);

    // R9: read reporting line error leaves transmit pending.
    tx_space = 1; line_err = 1; tick(1); line_err = 0; tick(1);
    chk("R3 line over tx", iir_data, 8'hC6);
    rd_iir = 1; tick(1); rd_iir = 0; tick(1);
    chk("R9 line still reported", iir_data, 8'hC6);
    rd_lsr = 1; tick(1); rd_lsr = 0; tick(1);
    chk("R9 tx survived read", iir_data, 8'hC2);
    chk("R4 lsr cleared line", {7'd0, irq}, 8'h01);

    // R10: value held for a long read while a line error arrives.
    rd_iir = 1; tick(1);
    line_err = 1;
    chk("R10 held during read a", iir_data, 8'hC2);
    tick(1); line_err = 0;
    chk("R10 held during read b", iir_data, 8'hC2);
    tick(1); rd_iir = 0; tick(1);
    chk("R10 new value after read", iir_data, 8'hC6);

    // R4: set and clear in the same cycle keeps line pending.
    line_err = 1; rd_lsr = 1; tick(1); line_err = 0; rd_lsr = 0; tick(1);
    chk("R4 set wins", iir_data, 8'hC6);
    rd_lsr = 1; tick(1); rd_lsr = 0; tx_space = 0; tick(2);
    chk("R4 line cleared", iir_data, 8'hC1);

    // R8: transmit write clears.
    tx_space = 1; tick(2);
    wr_thr = 1; tick(1); wr_thr = 0; tick(1);
    chk("R8 write clears tx", iir_data, 8'hC1);
    tx_space = 0; tick(1);

    // R5 non-FIFO receive, R7 timeout ignored.
    fifo_mode = 0; rx_full = 1; tick(2);
    chk("R5 full sets rxd", iir_data, 8'h04);
    rd_rbr = 1; tick(1); rd_rbr = 0; rx_full = 0; tick(1);
    chk("R5 read clears rxd", iir_data, 8'h01);
    rx_tmo = 1; tick(1); rx_tmo = 0; tick(1);
    chk("R7 tmo ignored non-fifo", iir_data, 8'h01);
    fifo_mode = 1; tick(2);
    chk("R7 no stale tmo", iir_data, 8'hC1);

    // R6/R7 FIFO mode: threshold, timeout, reset.
    rx_trig = 1; rx_tmo = 1; tick(1); rx_tmo = 0; tick(1);
    chk("R3 rxd over tmo", iir_data, 8'hC4);
    rx_fifo_reset = 1; tick(1); rx_fifo_reset = 0; tick(2);
    chk("R6 reset clears rxd", iir_data, 8'hC1);
    rx_trig = 0; tick(1);
    rx_tmo = 1; tick(1); rx_tmo = 0; tick(1);
    chk("R7 tmo code", iir_data, 8'hCC);
    rd_rbr = 1; tick(1); rd_rbr = 0; tick(1);
    chk("R7 read clears tmo", iir_data, 8'hC1);

    // R11 modem change and clear.
    mdm_lines = mdm_lines ^ 4'b1000; tick(2);
    chk("R11 modem set", iir_data, 8'hC0);
    rd_msr = 1; tick(1); rd_msr = 0; tick(1);
    chk("R11 msr clears", iir_data, 8'hC1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule